// File: doc/BRIEF.md
# Edge-Configurable Two-Line Interrupt Collector

This block gathers N raw event signals from one functional area of a power-management device and turns them into two level interrupt outputs. Each raw input is first brought into the local clock domain by a two-stage synchronizer. Edge detection then runs on the synchronized value, with a per-source 2-bit selector that picks rising edges, falling edges, both, or neither. Every detected event is latched in two independent status registers, one per interrupt line. Each line has its own mask register, so one processor can watch a source that another processor ignores.

Software reaches the block through a byte-addressed register port with separate read and write strobes. Read data is combinational and is valid in the same cycle as the read strobe. A control bit selects how status is cleared. In clear-on-read mode, a read of a status byte clears the bits it returned. In the other mode, software clears a bit by writing a 1 to it.

The register map, with bytes little-endian, NB = ceil(N/8) and EB = ceil(2N/8):

| Address | Contents |
|---|---|
| 0x00 | control; bit 0 is the clear-on-read enable |
| 0x10 + k | line 0 status, byte k |
| 0x14 + k | line 0 mask, byte k |
| 0x18 + k | line 1 status, byte k |
| 0x1C + k | line 1 mask, byte k |
| 0x20 + k | edge selectors, byte k |

Top module: `ixs_top`

## Requirements
- R1: After reset the status registers are 0, every existing mask bit is 1, the edge selectors are 0, the control register is 0 and both `irq_out` bits are 0.
- R2: Source i owns the 2-bit field at bit offset (i&3)*2 of edge byte i>>2, which is address 0x20+(i>>2).
- R3: In that field, bit 1 enables rising-edge detection and bit 0 enables falling-edge detection; with both set, either edge is detected. An input change becomes visible in status after three rising clock edges.
- R4: A source whose 2-bit edge field is 00 never sets its status bit, whatever its input does.
- R5: A status bit sets on a detected edge even while it is masked. A mask bit of 1 blocks the source on its line. `irq_out[l]` is the OR over all sources of (status AND NOT mask) for line l.
- R6: The two lines hold separate status and mask copies. Clearing or masking a source on one line leaves the other line unchanged.
- R7: With control bit 0 at 0, writing 1 to a status bit clears it. Writing 0 has no effect, and reads do not clear.
- R8: With control bit 0 at 1, a read of a status byte clears the bits it returned. Writes to status are ignored.
- R9: Status and mask bits at positions N and above read as 0. Edge bits at positions 2N and above also read as 0.
- R10: When a detected edge and a clear reach the same status bit in the same cycle, the bit ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | N | Raw, asynchronous event inputs |
| reg_addr | input | 8 | Register byte address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe (clears status in clear-on-read mode) |
| reg_rdata | output | 8 | Read data, valid in the same cycle as `reg_rd` |
| irq_out | output | 2 | Level interrupt outputs, bit l belongs to line l |

## Verification
The hardest case to reach from the ports is R10: a clear must land in exactly the cycle in which the synchronized edge is seen. The bench drives a falling edge on a source whose status bit is already set. It then counts two clock edges through the synchronizer and issues the write-one-to-clear so that the write and the detected edge meet at the same clock edge. The bit must read back as still set. Masking is also tested one line at a time, with pending status on both lines, to show that the two lines do not interfere.

// File: rtl/ixs_pkg.sv
package ixs_pkg;

    localparam logic [7:0] A_CTRL = 8'h00;
    localparam logic [7:0] A_ST0  = 8'h10;
    localparam logic [7:0] A_MK0  = 8'h14;
    localparam logic [7:0] A_ST1  = 8'h18;
    localparam logic [7:0] A_MK1  = 8'h1C;
    localparam logic [7:0] A_EDGE = 8'h20;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_CTRL,
        RK_STAT,
        RK_MASK,
        RK_EDGE
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic       line;
        logic [2:0] idx;
    } reg_sel_t;

    function automatic logic in_win(logic [7:0] a, logic [7:0] base, int n);
        return (int'(a) >= int'(base)) && (int'(a) < int'(base) + n);
    endfunction

    function automatic logic [2:0] win_idx(logic [7:0] a, logic [7:0] base);
        logic [7:0] off;
        off = a - base;
        return off[2:0];
    endfunction

    function automatic reg_sel_t decode(logic [7:0] a, int nb, int eb);
        reg_sel_t s;
        s = '{kind: RK_NONE, line: 1'b0, idx: 3'd0};
        if (a == A_CTRL) begin
            s.kind = RK_CTRL;
        end else if (in_win(a, A_ST0, nb)) begin
            s = '{kind: RK_STAT, line: 1'b0, idx: win_idx(a, A_ST0)};
        end else if (in_win(a, A_MK0, nb)) begin
            s = '{kind: RK_MASK, line: 1'b0, idx: win_idx(a, A_MK0)};
        end else if (in_win(a, A_ST1, nb)) begin
            s = '{kind: RK_STAT, line: 1'b1, idx: win_idx(a, A_ST1)};
        end else if (in_win(a, A_MK1, nb)) begin
            s = '{kind: RK_MASK, line: 1'b1, idx: win_idx(a, A_MK1)};
        end else if (in_win(a, A_EDGE, eb)) begin
            s = '{kind: RK_EDGE, line: 1'b0, idx: win_idx(a, A_EDGE)};
        end
        return s;
    endfunction

    // cfg[1] arms the rising edge, cfg[0] arms the falling edge
    function automatic logic edge_hit(logic [1:0] cfg, logic now, logic was);
        return (cfg[1] & now & ~was) | (cfg[0] & ~now & was);
    endfunction

endpackage

// File: rtl/ixs_edge_det.sv
module ixs_edge_det
    import ixs_pkg::*;
#(
    parameter int N = 12
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [N-1:0]   src_in,
    input  logic [2*N-1:0] edge_cfg,
    output logic [N-1:0]   event_o
);
    logic [N-1:0] sync1_q, sync2_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1_q <= '0;
            sync2_q <= '0;
            prev_q  <= '0;
        end else begin
            sync1_q <= src_in;
            sync2_q <= sync1_q;
            prev_q  <= sync2_q;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_src
        assign event_o[i] = edge_hit(edge_cfg[2*i +: 2], sync2_q[i], prev_q[i]);
    end
endmodule

// File: rtl/ixs_line.sv
module ixs_line
    import ixs_pkg::*;
#(
    parameter int N = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] event_i,
    input  logic         cor_i,
    input  logic         wr_i,
    input  logic         rd_i,
    input  logic         stat_sel_i,
    input  logic         mask_sel_i,
    input  logic [2:0]   idx_i,
    input  logic [7:0]   wdata_i,
    output logic [N-1:0] stat_o,
    output logic [N-1:0] mask_o,
    output logic [N-1:0] clr_o,
    output logic         irq_o
);
    logic [N-1:0] st_q, mk_q, mwe;

    for (genvar i = 0; i < N; i++) begin : g_bit
        localparam int B = i / 8;
        localparam int K = i % 8;
        logic hit;
        assign hit     = (idx_i == 3'(B));
        assign clr_o[i] = (rd_i & stat_sel_i & hit & cor_i)
                        | (wr_i & stat_sel_i & hit & ~cor_i & wdata_i[K]);
        assign mwe[i]   = wr_i & mask_sel_i & hit;

        always_ff @(posedge clk) begin
            if (rst) begin
                mk_q[i] <= 1'b1;
            end else if (mwe[i]) begin
                mk_q[i] <= wdata_i[K];
            end
        end
    end

    // a new event outranks a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= (st_q & ~clr_o) | event_i;
    end

    assign stat_o = st_q;
    assign mask_o = mk_q;
    assign irq_o  = |(st_q & ~mk_q);
endmodule

// File: rtl/ixs_top.sv
module ixs_top
    import ixs_pkg::*;
#(
    parameter int N = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] src_in,
    input  logic [7:0]   reg_addr,
    input  logic         reg_wr,
    input  logic [7:0]   reg_wdata,
    input  logic         reg_rd,
    output logic [7:0]   reg_rdata,
    output logic [1:0]   irq_out
);
    localparam int NB = (N + 7) / 8;
    localparam int EB = (2 * N + 7) / 8;

    reg_sel_t               sel;
    logic                   cor_q;
    logic [2*N-1:0]         edge_q;
    logic [N-1:0]           ev_w;
    logic [1:0][N-1:0]      st_w, mk_w, clr_w;

    assign sel = decode(reg_addr, NB, EB);

    always_ff @(posedge clk) begin
        if (rst)                                 cor_q <= 1'b0;
        else if (reg_wr && sel.kind == RK_CTRL)  cor_q <= reg_wdata[0];
    end

    for (genvar j = 0; j < 2 * N; j++) begin : g_edge
        localparam int B = j / 8;
        localparam int K = j % 8;
        always_ff @(posedge clk) begin
            if (rst)
                edge_q[j] <= 1'b0;
            else if (reg_wr && sel.kind == RK_EDGE && sel.idx == 3'(B))
                edge_q[j] <= reg_wdata[K];
        end
    end

    ixs_edge_det #(.N(N)) u_det (
        .clk      (clk),
        .rst      (rst),
        .src_in   (src_in),
        .edge_cfg (edge_q),
        .event_o  (ev_w)
    );

    for (genvar l = 0; l < 2; l++) begin : g_line
        logic mine;
        assign mine = (sel.line == 1'(l));
        ixs_line #(.N(N)) u_line (
            .clk        (clk),
            .rst        (rst),
            .event_i    (ev_w),
            .cor_i      (cor_q),
            .wr_i       (reg_wr & mine),
            .rd_i       (reg_rd & mine),
            .stat_sel_i (sel.kind == RK_STAT),
            .mask_sel_i (sel.kind == RK_MASK),
            .idx_i      (sel.idx),
            .wdata_i    (reg_wdata),
            .stat_o     (st_w[l]),
            .mask_o     (mk_w[l]),
            .clr_o      (clr_w[l]),
            .irq_o      (irq_out[l])
        );
    end

    always_comb begin
        reg_rdata = 8'h00;
        unique case (sel.kind)
            RK_CTRL: reg_rdata[0] = cor_q;
            RK_STAT: for (int i = 0; i < N; i++)
                         if (i / 8 == int'(sel.idx)) reg_rdata[i % 8] = st_w[sel.line][i];
            RK_MASK: for (int i = 0; i < N; i++)
                         if (i / 8 == int'(sel.idx)) reg_rdata[i % 8] = mk_w[sel.line][i];
            RK_EDGE: for (int j = 0; j < 2 * N; j++)
                         if (j / 8 == int'(sel.idx)) reg_rdata[j % 8] = edge_q[j];
            default: reg_rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/ixs_chk.sv
module ixs_chk
    import ixs_pkg::*;
#(
    parameter int N = 12
) (
    input logic              clk,
    input logic              rst,
    input logic [N-1:0]      ev,
    input logic [2*N-1:0]    edge_q,
    input logic [1:0][N-1:0] st,
    input logic [1:0][N-1:0] mask,
    input logic [1:0][N-1:0] clr,
    input logic              reg_rd,
    input logic [7:0]        reg_addr,
    input logic [7:0]        reg_rdata
);
    localparam int NB = (N + 7) / 8;
    localparam int TOPB = N - 8 * (NB - 1);
    localparam logic [7:0] ZMASK = 8'hFF << TOPB;

    logic [N-1:0] armed;
    always_comb
        for (int i = 0; i < N; i++) armed[i] = edge_q[2*i] | edge_q[2*i+1];

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mask[0] == '1 && mask[1] == '1 && st == '0));

    for (genvar l = 0; l < 2; l++) begin : g_l
        // R5
        status_sticky_chk: assert property (@(posedge clk) disable iff (rst)
            (($past(st[l]) & ~$past(clr[l]) & ~st[l]) == '0));
        // R10
        event_wins_chk: assert property (@(posedge clk) disable iff (rst)
            (($past(ev) & $past(clr[l]) & ~st[l]) == '0));
        // R4
        unarmed_quiet_chk: assert property (@(posedge clk) disable iff (rst)
            ((st[l] & ~$past(st[l]) & ~$past(armed)) == '0));
    end

    // R9
    top_byte_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && (reg_addr == A_ST0 + 8'(NB - 1) || reg_addr == A_ST1 + 8'(NB - 1)))
            |-> ((reg_rdata & ZMASK) == 8'h00));
endmodule

bind ixs_top ixs_chk #(.N(N)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ev        (ev_w),
    .edge_q    (edge_q),
    .st        (st_w),
    .mask      (mk_w),
    .clr       (clr_w),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata)
);

// File: tb/sim_ixs_top.sv
module sim_ixs_top;
    localparam int N = 12;
    localparam logic [7:0] CTRL = 8'h00, ST0 = 8'h10, MK0 = 8'h14,
                           ST1 = 8'h18, MK1 = 8'h1C, EDG = 8'h20;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] src_in = '0;
    logic [7:0]   reg_addr = '0, reg_wdata = '0;
    logic         reg_wr = 1'b0, reg_rd = 1'b0, irq_req = 1'b0;
    logic [7:0]   reg_rdata;
    logic [1:0]   irq_out;
    int total = 0, bad = 0;

    typedef struct { bit is_irq; logic [7:0] exp; string tag; } item_t;
    item_t q[$];

    always #2 clk = ~clk;

    ixs_top #(.N(N)) u0 (.clk(clk), .rst(rst), .src_in(src_in),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rd(reg_rd), .reg_rdata(reg_rdata), .irq_out(irq_out));

    // monitor: pops expected items and compares mid-cycle
    initial forever begin
        item_t it;
        logic [7:0] act;
        @(negedge clk); #1;
        if (reg_rd || irq_req) begin
            total++;
            if (q.size() == 0) begin
                bad++;
                $display("FAIL scoreboard empty");
            end else begin
                it  = q.pop_front();
                act = it.is_irq ? {6'b0, irq_out} : reg_rdata;
                if (act !== it.exp) begin
                    bad++;
                    $display("FAIL %s actual=%02h expected=%02h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
        @(negedge clk); reg_addr = a; reg_rd = 1'b1;
        q.push_back('{is_irq: 1'b0, exp: e, tag: tag});
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic irq_chk(input logic [1:0] e, input string tag);
        @(negedge clk); irq_req = 1'b1;
        q.push_back('{is_irq: 1'b1, exp: {6'b0, e}, tag: tag});
        @(negedge clk); irq_req = 1'b0;
    endtask

    task automatic set_src(input logic [N-1:0] v);
        @(negedge clk); src_in = v;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state, R9 unused mask bits
        rd(ST0, 8'h00, "R1");
        rd(MK0, 8'hFF, "R1");
        rd(MK1 + 8'd1, 8'h0F, "R9");
        rd(EDG, 8'h00, "R1");
        rd(CTRL, 8'h00, "R1");
        irq_chk(2'b00, "R1");
        // R4 unarmed sources
        set_src(12'hFFF);
        set_src(12'h000);
        rd(ST0, 8'h00, "R4");
        rd(ST1, 8'h00, "R4");
        // R2/R3: src0 rise, src1 fall, src2 both, src3 none
        wr(EDG, 8'h36);
        rd(EDG, 8'h36, "R2");
        set_src(12'h00F);
        rd(ST0, 8'h05, "R3");
        rd(ST1, 8'h05, "R3");
        irq_chk(2'b00, "R5");
        wr(ST0, 8'h05);
        wr(ST1, 8'h05);
        rd(ST0, 8'h00, "R7");
        set_src(12'h000);
        rd(ST0, 8'h06, "R3");
        // R7 write-one-to-clear, R6 line independence
        wr(ST0, 8'h02);
        rd(ST0, 8'h04, "R7");
        wr(ST0, 8'h00);
        rd(ST0, 8'h04, "R7");
        rd(ST1, 8'h06, "R6");
        // R5 masking per line
        wr(MK1, 8'hFB);
        irq_chk(2'b10, "R5");
        wr(MK0, 8'hFD);
        irq_chk(2'b10, "R6");
        wr(MK0, 8'hFB);
        rd(MK0, 8'hFB, "R5");
        irq_chk(2'b11, "R5");
        // R8 clear-on-read
        wr(CTRL, 8'h01);
        rd(CTRL, 8'h01, "R8");
        wr(ST0, 8'h04);
        rd(ST0, 8'h04, "R8");
        rd(ST0, 8'h00, "R8");
        irq_chk(2'b10, "R8");
        rd(ST1, 8'h06, "R8");
        rd(ST1, 8'h00, "R8");
        irq_chk(2'b00, "R8");
        // R9 top source and unused bits
        wr(EDG + 8'd2, 8'h80);
        rd(EDG + 8'd2, 8'h80, "R2");
        set_src(12'h800);
        rd(ST0 + 8'd1, 8'h08, "R9");
        rd(ST0 + 8'd1, 8'h00, "R8");
        rd(ST1 + 8'd1, 8'h08, "R9");
        wr(MK0 + 8'd1, 8'hFF);
        rd(MK0 + 8'd1, 8'h0F, "R9");
        // R10 clear collides with falling edge on src5
        wr(CTRL, 8'h00);
        wr(EDG + 8'd1, 8'h0C);
        set_src(12'h820);
        rd(ST0, 8'h20, "R3");
        @(negedge clk); src_in = 12'h800;
        @(negedge clk);
        wr(ST0, 8'h20);
        rd(ST0, 8'h20, "R10");
        wr(ST0, 8'h20);
        rd(ST0, 8'h00, "R7");
        rd(ST1, 8'h20, "R6");
        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule